// File: doc/BRIEF.md
# Signed 8-bit Cell Datapath with Multiply-Accumulate

This block is the arithmetic heart of a small DSP-style cell. Every clock it takes two 8-bit operands, a 14-bit control word and an accumulate enable. It performs one of four kinds of work on them: signed add, subtract, negate or multiply; a logic operation, optionally complemented; a barrel shift, rotate or shift-out; or a signed comparison. It returns a 16-bit result and a set of condition flags.

The operands, control word and accumulate enable are captured in an input register bank. The result and flags are captured in an output register bank. A new operation can therefore start every clock, and its outputs appear two clock edges after they are presented. A separate 16-bit accumulator sits in the output bank. It is written only by multiply-accumulate operations, so ordinary operations can be interleaved between the steps of a dot product. Rotation has no dedicated rotator: the barrel shifter produces the two shifted halves and the logic unit ORs them together.

Top module: `pe_cell`

## Requirements
- R1: While rst_n is low, result_o is 0 and every flag output (carry_o, ovf_o, eq_o, lt_o, gt_o, sat_o) is 0. The accumulator is 0 when reset is released.
- R2: Inputs sampled at clock edge k produce their result and flags on the outputs just after edge k+1. A different operation may be presented at every edge.
- R3: ctrl_i[1:0] selects the unit (00 arithmetic, 01 logic, 10 shift, 11 compare), and ctrl_i[3:2] selects the function within that unit.
  - Arithmetic functions are 00 add, 01 subtract A-B, 11 negate (0-A), and 10 multiply.
  - Add, subtract and negate give the 8-bit two's-complement result, sign-extended to 16 bits.
  - carry_o is the unsigned carry-out for add, and the unsigned borrow for subtract and negate.
  - ovf_o is signed overflow.
- R4: Multiply (arithmetic function 10) with the registered accumulate enable low returns the full signed 16-bit product. Its carry_o and ovf_o are 0.
- R5: Logic functions are 00 AND, 01 OR, 10 XOR and 11 pass A. ctrl_i[4]=1 returns the bitwise complement of that result. The result is zero-extended, and carry_o and ovf_o are 0.
- R6: Shift functions are 00 shift left, 01 logical shift right and 10 arithmetic shift right. The shift amount is B[2:0] and the result is zero-extended. carry_o is the last bit shifted out: A[8-k] for left, A[k-1] for right. It is 0 when k=0.
- R7: Shift function 11 is rotate right by k=B[2:0], equal to (A>>k)|(A<<(8-k)) in 8 bits. k=0 returns A unchanged. carry_o is 0.
- R8: Compare raises exactly one of eq_o, lt_o, gt_o, according to the signed relation of A to B. Its result is the signed maximum of A and B, sign-extended. Every other unit drives these three flags to 0.
- R9: ctrl_i[5]=1 exchanges A and B before any unit sees them.
- R10: Multiply with acc_en_i=1 writes the accumulator with accumulator+product. If ctrl_i[6]=1, the accumulator is first taken as 0. The result output shows the new accumulator value. No other operation changes the accumulator.
- R11: The accumulate sum saturates to 32767 or -32768. sat_o is 1 exactly for an accumulate step that clipped.
- R12: ctrl_i[13:7] have no effect on any output or on the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a_i | input | 8 | Operand A |
| op_b_i | input | 8 | Operand B, also the shift amount in bits [2:0] |
| ctrl_i | input | 14 | Control word: unit, function, complement, swap, clear, reserved |
| acc_en_i | input | 1 | Accumulate enable for multiply |
| result_o | output | 16 | Registered result |
| carry_o | output | 1 | Carry, borrow or shifted-out bit |
| ovf_o | output | 1 | Signed overflow |
| eq_o | output | 1 | Compare: A equals B |
| lt_o | output | 1 | Compare: A less than B, signed |
| gt_o | output | 1 | Compare: A greater than B, signed |
| sat_o | output | 1 | Accumulate step clipped |

## Verification
The bench targets the overflow edges of 8-bit arithmetic: 127+1, 0x80-1, negating 0x80 and -128 times -128. A datapath that confused carry with signed overflow, or multiplied unsigned, would show wrong flags or a wrong product on exactly these cases.

Shifts and rotates are driven with amounts 0 and 7. These are where a shifter that mishandled the complementary 8-k amount would return 0 instead of A, or would report a phantom shifted-out bit.

Accumulation runs into both saturation limits, where a wrapping adder would flip sign. It also interleaves ordinary operations between accumulate steps, exposing an accumulator that was overwritten by every result.

Back-to-back operations check that results emerge in order two edges after entry, and randomised control words with random reserved bits catch stray decoding.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'b00,
    UNIT_LOGIC = 2'b01,
    UNIT_SHIFT = 2'b10,
    UNIT_CMP   = 2'b11
  } unit_e;

  // control word field positions
  localparam int CF_UNIT_LO = 0;
  localparam int CF_FN_LO   = 2;
  localparam int CF_INV     = 4;
  localparam int CF_SWAP    = 5;
  localparam int CF_CLR     = 6;

  // arithmetic functions
  localparam logic [1:0] AF_ADD = 2'b00;
  localparam logic [1:0] AF_SUB = 2'b01;
  localparam logic [1:0] AF_MUL = 2'b10;
  localparam logic [1:0] AF_NEG = 2'b11;

  // logic functions
  localparam logic [1:0] LF_AND  = 2'b00;
  localparam logic [1:0] LF_OR   = 2'b01;
  localparam logic [1:0] LF_XOR  = 2'b10;
  localparam logic [1:0] LF_PASS = 2'b11;

  // shift functions
  localparam logic [1:0] SF_SHL = 2'b00;
  localparam logic [1:0] SF_SHR = 2'b01;
  localparam logic [1:0] SF_SAR = 2'b10;
  localparam logic [1:0] SF_ROR = 2'b11;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic eq;
    logic lt;
    logic gt;
    logic sat;
  } flags_t;

endpackage

// File: rtl/pe_shifter.sv
module pe_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0]         a_i,
  input  logic [$clog2(W)-1:0] amt_i,
  output logic [W-1:0]         shl_o,
  output logic [W-1:0]         shr_o,
  output logic [W-1:0]         sar_o,
  output logic [W-1:0]         rem_o,
  output logic                 out_l_o,
  output logic                 out_r_o
);

  localparam int SW = $clog2(W);

  // W+1 wide stages keep the bit that falls off the end
  logic [W:0]   lx [0:SW];
  logic [W:0]   rx [0:SW];
  logic [W:0]   ax [0:SW];
  logic [W-1:0] cx [0:SW+1];
  logic [SW:0]  camt;

  assign camt  = (SW+1)'(W) - {1'b0, amt_i};
  assign lx[0] = {1'b0, a_i};
  assign rx[0] = {a_i, 1'b0};
  assign ax[0] = {a_i, 1'b0};
  assign cx[0] = a_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    assign lx[s+1] = amt_i[s] ? (lx[s] << (2**s)) : lx[s];
    assign rx[s+1] = amt_i[s] ? (rx[s] >> (2**s)) : rx[s];
    assign ax[s+1] = amt_i[s] ? (W+1)'($signed(ax[s]) >>> (2**s)) : ax[s];
  end

  // complementary amount W-k, one stage wider so W itself is reachable
  for (genvar s = 0; s <= SW; s++) begin : g_cstage
    assign cx[s+1] = camt[s] ? (cx[s] << (2**s)) : cx[s];
  end

  assign shl_o   = lx[SW][W-1:0];
  assign out_l_o = lx[SW][W];
  assign shr_o   = rx[SW][W:1];
  assign out_r_o = rx[SW][0];
  assign sar_o   = ax[SW][W:1];
  assign rem_o   = cx[SW+1];

endmodule

// File: rtl/pe_logic.sv
module pe_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [1:0]   fn_i,
  input  logic         inv_i,
  output logic [W-1:0] z_o
);

  import pe_pkg::*;

  logic [W-1:0] raw;

  always_comb begin
    unique case (fn_i)
      LF_AND:  raw = x_i & y_i;
      LF_OR:   raw = x_i | y_i;
      LF_XOR:  raw = x_i ^ y_i;
      default: raw = x_i;
    endcase
    z_o = inv_i ? ~raw : raw;
  end

endmodule

// File: rtl/pe_arith.sv
module pe_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [1:0]     fn_i,
  output logic [W-1:0]   sum_o,
  output logic           carry_o,
  output logic           ovf_o,
  output logic [2*W-1:0] prod_o,
  output logic           eq_o,
  output logic           lt_o,
  output logic           gt_o,
  output logic [W-1:0]   max_o
);

  import pe_pkg::*;

  logic [W:0]            add_x, sub_x, neg_x;
  logic signed [2*W-1:0] a_ext, b_ext;

  assign add_x = {1'b0, a_i} + {1'b0, b_i};
  assign sub_x = {1'b0, a_i} - {1'b0, b_i};
  assign neg_x = '0 - {1'b0, a_i};

  always_comb begin
    sum_o   = '0;
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    unique case (fn_i)
      AF_ADD: begin
        sum_o   = add_x[W-1:0];
        carry_o = add_x[W];
        ovf_o   = (a_i[W-1] == b_i[W-1]) && (add_x[W-1] != a_i[W-1]);
      end
      AF_SUB: begin
        sum_o   = sub_x[W-1:0];
        carry_o = sub_x[W];
        ovf_o   = (a_i[W-1] != b_i[W-1]) && (sub_x[W-1] != a_i[W-1]);
      end
      AF_NEG: begin
        sum_o   = neg_x[W-1:0];
        carry_o = neg_x[W];
        ovf_o   = a_i[W-1] && neg_x[W-1];
      end
      default: ;
    endcase
  end

  assign a_ext  = $signed({{W{a_i[W-1]}}, a_i});
  assign b_ext  = $signed({{W{b_i[W-1]}}, b_i});
  assign prod_o = a_ext * b_ext;

  assign eq_o  = (a_i == b_i);
  assign lt_o  = $signed(a_i) < $signed(b_i);
  assign gt_o  = !eq_o && !lt_o;
  assign max_o = lt_o ? b_i : a_i;

endmodule

// File: rtl/pe_cell.sv
module pe_cell #(
  parameter int DW = 8,
  parameter int CW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  op_a_i,
  input  logic [DW-1:0]  op_b_i,
  input  logic [CW-1:0]  ctrl_i,
  input  logic           acc_en_i,
  output logic [2*DW-1:0] result_o,
  output logic           carry_o,
  output logic           ovf_o,
  output logic           eq_o,
  output logic           lt_o,
  output logic           gt_o,
  output logic           sat_o
);

  import pe_pkg::*;

  localparam int RW = 2*DW;
  localparam int SW = $clog2(DW);
  localparam logic signed [RW:0] SAT_HI = {2'b00, {(RW-1){1'b1}}};
  localparam logic signed [RW:0] SAT_LO = {2'b11, {(RW-1){1'b0}}};

  // ---------------- input register bank ----------------
  logic [DW-1:0] a_q, b_q;
  logic [CW-1:0] ctrl_q;
  logic          acc_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q      <= '0;
      b_q      <= '0;
      ctrl_q   <= '0;
      acc_en_q <= 1'b0;
    end else begin
      a_q      <= op_a_i;
      b_q      <= op_b_i;
      ctrl_q   <= ctrl_i;
      acc_en_q <= acc_en_i;
    end
  end

  // ---------------- decode ----------------
  unit_e         unit;
  logic [1:0]    fn;
  logic          inv, swap, clr;
  logic [DW-1:0] x, y;

  assign unit = unit_e'(ctrl_q[CF_UNIT_LO +: 2]);
  assign fn   = ctrl_q[CF_FN_LO +: 2];
  assign inv  = ctrl_q[CF_INV];
  assign swap = ctrl_q[CF_SWAP];
  assign clr  = ctrl_q[CF_CLR];
  assign x    = swap ? b_q : a_q;
  assign y    = swap ? a_q : b_q;

  // ---------------- units ----------------
  logic [DW-1:0] shl, shr, sar, rem;
  logic          out_l, out_r;

  pe_shifter #(.W(DW)) u_shift (
    .a_i     (x),
    .amt_i   (y[SW-1:0]),
    .shl_o   (shl),
    .shr_o   (shr),
    .sar_o   (sar),
    .rem_o   (rem),
    .out_l_o (out_l),
    .out_r_o (out_r)
  );

  // rotate reuses the logic unit to merge the two shifted halves
  logic          rot_sel;
  logic [DW-1:0] lu_x, lu_y, lu_z;
  logic [1:0]    lu_fn;
  logic          lu_inv;

  assign rot_sel = (unit == UNIT_SHIFT) && (fn == SF_ROR);
  assign lu_x    = rot_sel ? shr   : x;
  assign lu_y    = rot_sel ? rem   : y;
  assign lu_fn   = rot_sel ? LF_OR : fn;
  assign lu_inv  = rot_sel ? 1'b0  : inv;

  pe_logic #(.W(DW)) u_logic (
    .x_i   (lu_x),
    .y_i   (lu_y),
    .fn_i  (lu_fn),
    .inv_i (lu_inv),
    .z_o   (lu_z)
  );

  logic [DW-1:0] ar_sum, ar_max;
  logic          ar_c, ar_v, ar_eq, ar_lt, ar_gt;
  logic [RW-1:0] ar_prod;

  pe_arith #(.W(DW)) u_arith (
    .a_i     (x),
    .b_i     (y),
    .fn_i    (fn),
    .sum_o   (ar_sum),
    .carry_o (ar_c),
    .ovf_o   (ar_v),
    .prod_o  (ar_prod),
    .eq_o    (ar_eq),
    .lt_o    (ar_lt),
    .gt_o    (ar_gt),
    .max_o   (ar_max)
  );

  // ---------------- accumulate ----------------
  logic [RW-1:0]     acc_q;
  logic [RW-1:0]     acc_d;
  logic              acc_we;
  logic              mac_now;
  logic [RW-1:0]     acc_base;
  logic signed [RW:0] acc_sum;
  logic              acc_clip;

  assign mac_now  = (unit == UNIT_ARITH) && (fn == AF_MUL) && acc_en_q;
  assign acc_base = clr ? '0 : acc_q;
  assign acc_sum  = $signed({acc_base[RW-1], acc_base}) + $signed({ar_prod[RW-1], ar_prod});

  always_comb begin
    acc_clip = 1'b0;
    acc_d    = acc_sum[RW-1:0];
    if (acc_sum > SAT_HI) begin
      acc_d    = SAT_HI[RW-1:0];
      acc_clip = 1'b1;
    end else if (acc_sum < SAT_LO) begin
      acc_d    = SAT_LO[RW-1:0];
      acc_clip = 1'b1;
    end
  end

  assign acc_we = mac_now;

  // ---------------- result next state ----------------
  logic [RW-1:0] res_d;
  flags_t        flg_d;

  always_comb begin
    res_d = '0;
    flg_d = '0;
    unique case (unit)
      UNIT_ARITH: begin
        if (fn == AF_MUL) begin
          res_d     = mac_now ? acc_d : ar_prod;
          flg_d.sat = mac_now && acc_clip;
        end else begin
          res_d     = {{DW{ar_sum[DW-1]}}, ar_sum};
          flg_d.carry = ar_c;
          flg_d.ovf   = ar_v;
        end
      end
      UNIT_LOGIC: begin
        res_d = {{DW{1'b0}}, lu_z};
      end
      UNIT_SHIFT: begin
        unique case (fn)
          SF_SHL: begin
            res_d       = {{DW{1'b0}}, shl};
            flg_d.carry = out_l;
          end
          SF_SHR: begin
            res_d       = {{DW{1'b0}}, shr};
            flg_d.carry = out_r;
          end
          SF_SAR: begin
            res_d       = {{DW{1'b0}}, sar};
            flg_d.carry = out_r;
          end
          default: begin
            res_d = {{DW{1'b0}}, lu_z};
          end
        endcase
      end
      default: begin
        res_d    = {{DW{ar_max[DW-1]}}, ar_max};
        flg_d.eq = ar_eq;
        flg_d.lt = ar_lt;
        flg_d.gt = ar_gt;
      end
    endcase
  end

  // ---------------- output register bank ----------------
  logic [RW-1:0] result_q;
  flags_t        flg_q;
  unit_e         unit_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      flg_q    <= '0;
      unit_r   <= UNIT_ARITH;
    end else begin
      result_q <= res_d;
      flg_q    <= flg_d;
      unit_r   <= unit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_we) begin
      acc_q <= acc_d;
    end
  end

  assign result_o = result_q;
  assign carry_o  = flg_q.carry;
  assign ovf_o    = flg_q.ovf;
  assign eq_o     = flg_q.eq;
  assign lt_o     = flg_q.lt;
  assign gt_o     = flg_q.gt;
  assign sat_o    = flg_q.sat;

  // ---------------- assertions ----------------
  AST_ACC_ONLY_MAC: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_now |=> $stable(acc_q)); // R10

  AST_SAT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |-> (result_o == SAT_HI[RW-1:0] || result_o == SAT_LO[RW-1:0])); // R11

  AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_r == UNIT_CMP) |-> $onehot({eq_o, lt_o, gt_o})); // R8

  AST_CMP_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_r != UNIT_CMP) |-> !(eq_o || lt_o || gt_o)); // R8

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_r == UNIT_LOGIC) |-> !(carry_o || ovf_o || sat_o)); // R5

endmodule

// File: tb/pe_cell_tb_top.sv
module pe_cell_tb_top;

  logic        clk;
  logic        rst_n;
  logic [7:0]  op_a, op_b;
  logic [13:0] ctrl;
  logic        acc_en;
  logic [15:0] result;
  logic        carry, ovf, eq, lt, gt, sat;

  int checks;
  int failures;
  int m_acc;

  localparam logic [13:0] IDLE = 14'h000D; // logic unit, pass A

  pe_cell dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a_i   (op_a),
    .op_b_i   (op_b),
    .ctrl_i   (ctrl),
    .acc_en_i (acc_en),
    .result_o (result),
    .carry_o  (carry),
    .ovf_o    (ovf),
    .eq_o     (eq),
    .lt_o     (lt),
    .gt_o     (gt),
    .sat_o    (sat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int sx8(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction

  function automatic logic [13:0] cw(input int unit, input int fn, input bit inv,
                                     input bit swp, input bit clr);
    logic [13:0] c;
    c = '0;
    c[1:0] = unit[1:0];
    c[3:2] = fn[1:0];
    c[4]   = inv;
    c[5]   = swp;
    c[6]   = clr;
    return c;
  endfunction

  // reference model; flags packed as {carry, ovf, eq, lt, gt, sat}
  task automatic model(input logic [7:0] ai, input logic [7:0] bi, input logic [13:0] c,
                       input bit ae, output logic [15:0] r, output logic [5:0] f);
    logic [7:0] a, b, t8;
    int sa, sb, s, k, u, fn;
    r = '0;
    f = '0;
    a = c[5] ? bi : ai;
    b = c[5] ? ai : bi;
    sa = sx8(a);
    sb = sx8(b);
    u = int'(c[1:0]);
    fn = int'(c[3:2]);
    k = int'(b[2:0]);
    case (u)
      0: begin
        if (fn == 2) begin
          s = sa * sb;
          if (ae) begin
            s = (c[6] ? 0 : m_acc) + s;
            if (s > 32767) begin s = 32767; f[0] = 1'b1; end
            if (s < -32768) begin s = -32768; f[0] = 1'b1; end
            m_acc = s;
          end
          r = s[15:0];
        end else begin
          if (fn == 0) begin
            s = sa + sb;
            f[5] = (int'(a) + int'(b)) > 255;
          end else if (fn == 1) begin
            s = sa - sb;
            f[5] = int'(a) < int'(b);
          end else begin
            s = -sa;
            f[5] = a != 8'h00;
          end
          f[4] = (s > 127) || (s < -128);
          t8 = s[7:0];
          r = {{8{t8[7]}}, t8};
        end
      end
      1: begin
        case (fn)
          0: t8 = a & b;
          1: t8 = a | b;
          2: t8 = a ^ b;
          default: t8 = a;
        endcase
        if (c[4]) t8 = ~t8;
        r = {8'h00, t8};
      end
      2: begin
        t8 = '0;
        for (int i = 0; i < 8; i++) begin
          case (fn)
            0: t8[i] = (i - k >= 0) ? a[i-k] : 1'b0;
            1: t8[i] = (i + k < 8) ? a[i+k] : 1'b0;
            2: t8[i] = (i + k < 8) ? a[i+k] : a[7];
            default: t8[i] = a[(i + k) % 8];
          endcase
        end
        if (k != 0 && fn == 0) f[5] = a[8-k];
        if (k != 0 && (fn == 1 || fn == 2)) f[5] = a[k-1];
        r = {8'h00, t8};
      end
      default: begin
        f[3] = sa == sb;
        f[2] = sa < sb;
        f[1] = sa > sb;
        s = (sa > sb) ? sa : sb;
        r = s[15:0];
      end
    endcase
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [13:0] c,
                        input bit ae, input string req);
    logic [15:0] er;
    logic [5:0]  ef, af;
    @(negedge clk);
    op_a = a; op_b = b; ctrl = c; acc_en = ae;
    @(negedge clk);
    op_a = 8'h00; op_b = 8'h00; ctrl = IDLE; acc_en = 1'b0;
    @(posedge clk);
    #5;
    model(a, b, c, ae, er, ef);
    af = {carry, ovf, eq, lt, gt, sat};
    check(result == er, req, "result", result, er);
    check(af == ef, req, "flags", {10'h0, af}, {10'h0, ef});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    m_acc = 0;
    rst_n = 1'b0;
    op_a = '0; op_b = '0; ctrl = IDLE; acc_en = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    check(result == 16'h0, "R1", "reset result", result, 16'h0);
    check({carry, ovf, eq, lt, gt, sat} == 6'b0, "R1", "reset flags",
          {10'h0, carry, ovf, eq, lt, gt, sat}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 add/sub/neg corners
    run_op(8'h7F, 8'h01, cw(0, 0, 0, 0, 0), 0, "R3");
    run_op(8'hFF, 8'h01, cw(0, 0, 0, 0, 0), 0, "R3");
    run_op(8'h80, 8'h01, cw(0, 1, 0, 0, 0), 0, "R3");
    run_op(8'h03, 8'h05, cw(0, 1, 0, 0, 0), 0, "R3");
    run_op(8'h80, 8'h00, cw(0, 3, 0, 0, 0), 0, "R3");
    run_op(8'h00, 8'h00, cw(0, 3, 0, 0, 0), 0, "R3");
    // R4 multiply
    run_op(8'h80, 8'h80, cw(0, 2, 0, 0, 0), 0, "R4");
    run_op(8'h80, 8'h7F, cw(0, 2, 0, 0, 0), 0, "R4");
    // R5 logic with complement
    for (int f = 0; f < 4; f++) begin
      run_op(8'hC5, 8'h3A, cw(1, f, 0, 0, 0), 0, "R5");
      run_op(8'hC5, 8'h3A, cw(1, f, 1, 0, 0), 0, "R5");
    end
    // R6 shifts, amounts 0 and 7
    for (int f = 0; f < 3; f++) begin
      run_op(8'h81, 8'h00, cw(2, f, 0, 0, 0), 0, "R6");
      run_op(8'h81, 8'h07, cw(2, f, 0, 0, 0), 0, "R6");
      run_op(8'hB4, 8'hF3, cw(2, f, 0, 0, 0), 0, "R6");
    end
    // R7 rotate
    run_op(8'hA5, 8'h00, cw(2, 3, 0, 0, 0), 0, "R7");
    run_op(8'h96, 8'h03, cw(2, 3, 1, 0, 0), 0, "R7");
    run_op(8'h01, 8'h07, cw(2, 3, 0, 0, 0), 0, "R7");
    // R8 compare
    run_op(8'h42, 8'h42, cw(3, 0, 0, 0, 0), 0, "R8");
    run_op(8'hF0, 8'h10, cw(3, 2, 0, 0, 0), 0, "R8");
    run_op(8'h10, 8'hF0, cw(3, 1, 0, 0, 0), 0, "R8");
    // R9 swap
    run_op(8'h03, 8'h09, cw(0, 1, 0, 1, 0), 0, "R9");
    run_op(8'h02, 8'hF0, cw(2, 0, 0, 1, 0), 0, "R9");
    // R10 / R11 accumulate to positive limit
    run_op(8'h7F, 8'h7F, cw(0, 2, 0, 0, 1), 1, "R10");
    run_op(8'h12, 8'h34, cw(0, 0, 0, 0, 0), 0, "R10");
    run_op(8'h7F, 8'h7F, cw(0, 2, 0, 0, 0), 0, "R10");
    run_op(8'h00, 8'h55, cw(0, 2, 0, 0, 0), 1, "R10");
    run_op(8'h7F, 8'h7F, cw(0, 2, 0, 0, 0), 1, "R10");
    run_op(8'h7F, 8'h7F, cw(0, 2, 0, 0, 0), 1, "R11");
    // negative limit
    run_op(8'h80, 8'h7F, cw(0, 2, 0, 0, 1), 1, "R11");
    run_op(8'h80, 8'h7F, cw(0, 2, 0, 0, 0), 1, "R11");
    run_op(8'h80, 8'h7F, cw(0, 2, 0, 0, 0), 1, "R11");
    run_op(8'h01, 8'h01, cw(0, 2, 0, 0, 0), 1, "R11");
    // R12 reserved bits
    run_op(8'h5A, 8'h0F, cw(1, 2, 0, 0, 0) | 14'h3F80, 0, "R12");
    run_op(8'h80, 8'h01, cw(0, 1, 0, 0, 0) | 14'h2A80, 0, "R12");
    run_op(8'h00, 8'h00, cw(0, 2, 0, 0, 0) | 14'h1F80, 1, "R12");

    // R2 back-to-back issue
    @(negedge clk);
    op_a = 8'h03; op_b = 8'h04; ctrl = cw(0, 0, 0, 0, 0); acc_en = 1'b0;
    @(negedge clk);
    op_a = 8'hF0; op_b = 8'h3C; ctrl = cw(1, 0, 0, 0, 0);
    @(posedge clk);
    #5;
    check(result == 16'h0007, "R2", "first of pair", result, 16'h0007);
    @(negedge clk);
    op_a = 8'h00; op_b = 8'h00; ctrl = IDLE;
    @(posedge clk);
    #5;
    check(result == 16'h0030, "R2", "second of pair", result, 16'h0030);

    // random mix, all requirements
    void'($urandom(32'd20240611));
    for (int n = 0; n < 600; n++) begin
      logic [13:0] rc;
      rc = 14'($urandom());
      run_op(8'($urandom()), 8'($urandom()), rc, 1'($urandom()), "R3-mix");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule